// File: doc/BRIEF.md
# Tunable Bias Controller Power-Mode Sequencer

This block decides the operating mode of a three-output high-voltage bias controller and holds the control registers that set those outputs. It watches a level that says whether the I/O supply is present and takes register write strobes (address, data, enable) from a serial front end that has already decoded the bus traffic. From these it drives the boost converter enable, the serial interface enable, a register-clear indication and, per output, one of three exclusive drive states: driven by its DAC code, high impedance, or pulled to ground.

There are four modes. With the supply absent the block sits in shutdown and keeps nothing. A rising supply level starts a transient startup phase. This phase reloads every register with its power-on default, turns the boost on and keeps the outputs floating. After a fixed number of clocks, which stands in for bias settling, the block enters active mode by itself. In active mode, software can move it into a low-power mode that keeps the registers, or back into startup for a full reset, by writing a two-bit power-mode field.

Top module: `tuner_bias_ctrl`

## Requirements
- R1: While `vio_ok` is low at a clock edge, after that edge `mode_o` is 11 (shutdown), `boost_en` and `iface_en` are 0, `regs_clr` is 1, every `out_hiz` bit is 1, and the register outputs hold their defaults. Synchronous reset gives the same state.
- R2: At the first edge with `vio_ok` high after shutdown, `mode_o` becomes 01 (startup). During startup `boost_en`, `iface_en` and `regs_clr` are 1 and all outputs are high-Z. The registers hold their defaults: `boost_code` 1011 (20 V), enable mask 000, and every DAC code 0.
- R3: Startup lasts exactly START_CYC clock cycles and is then followed by active mode (`mode_o` 00). While `vio_ok` stays high, active mode is kept: power-on is edge-triggered.
- R4: Register writes are accepted only in active or low-power mode, and they show on the outputs after the edge that samples the strobe. The register map: address 0x00 bits [2:0] are the enable mask (bit 0 is output A, bit 1 is B, bit 2 is C). Addresses 0x02, 0x03 and 0x04 hold the DAC codes of A, B and C in bits [6:0], and bit 7 is ignored. Address 0x10 bits [3:0] hold the boost code. Writes to any other address leave every output unchanged.
- R5: In active mode, each output is in exactly one state. It is high-Z when its mask bit is 0. It is pulled down when its mask bit is 1 and its DAC code is 0. Otherwise it is driven (`out_drv`).
- R6: A write of 10 to bits [7:6] of address 0x1C in active mode selects low power (`mode_o` 10). In low power the boost is off, the interface stays on, all outputs are high-Z, and the registers keep their values. A write of 00 in low power returns to active mode, and the outputs follow R5 again.
- R7: A write of 01 to the power-mode field in active or low-power mode enters startup, reloads all defaults and then follows R3.
- R8: A power-mode value of 11 changes nothing. Neither does 10 in low power or 00 in active mode.
- R9: Register writes made in low-power mode update the held codes (`dac_code`, `boost_code`). These codes are used when active mode is re-entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vio_ok | input | 1 | I/O supply present level, synchronous to clk |
| wr_en | input | 1 | Register write strobe from the serial front end |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 8 | Register data of the write |
| mode_o | output | 2 | Mode: 00 active, 01 startup, 10 low power, 11 shutdown |
| boost_en | output | 1 | Boost converter enable |
| boost_code | output | 4 | Boost level code, 9 V plus 1 V per step |
| iface_en | output | 1 | Serial interface enable |
| regs_clr | output | 1 | Register contents being cleared to defaults |
| out_drv | output | 3 | Per output: driven from its DAC code |
| out_hiz | output | 3 | Per output: high impedance |
| out_pd | output | 3 | Per output: pulled to ground |
| dac_code | output | 21 | DAC codes, output A in bits [6:0], B in [13:7], C in [20:14] |

## Verification
The assertions assume that `vio_ok` and the write strobe are already synchronous to `clk`. They also assume that a write to the power-mode address changes no other register. This lets the low-power entry check require the mask and boost code to stay stable. The stimulus drives all inputs on the falling edge. Random writes use the mapped addresses, unmapped ones and all four power-mode values, and short supply drops come at random points, including in the middle of startup. This keeps every input change clean with respect to the sampling edge.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'b00,
    PM_STARTUP = 2'b01,
    PM_LOWPWR  = 2'b10,
    PM_OFF     = 2'b11
  } pm_state_t;

  localparam logic [ADDR_W-1:0] A_MASK  = 5'h00;
  localparam logic [ADDR_W-1:0] A_DAC0  = 5'h02;
  localparam logic [ADDR_W-1:0] A_BOOST = 5'h10;
  localparam logic [ADDR_W-1:0] A_PMODE = 5'h1C;

  localparam logic [1:0] REQ_RUN     = 2'b00;
  localparam logic [1:0] REQ_RESTART = 2'b01;
  localparam logic [1:0] REQ_SLEEP   = 2'b10;
endpackage

// File: rtl/tbc_mode_fsm.sv
module tbc_mode_fsm
  import tbc_pkg::*;
#(
  parameter int START_CYC = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      vio_ok,
  input  logic      pm_req_vld,
  input  logic [1:0] pm_req,
  output pm_state_t st_q,
  output pm_state_t st_n
);
  localparam int CNT_W = $clog2(START_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(START_CYC - 1);

  logic             vio_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             vio_rise;

  assign vio_rise = vio_ok & ~vio_q;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (!vio_ok) begin
      st_n = PM_OFF;
    end else begin
      case (st_q)
        PM_OFF: if (vio_rise) begin
          st_n  = PM_STARTUP;
          cnt_n = '0;
        end
        PM_STARTUP: begin
          if (cnt_q == LAST) st_n = PM_ACTIVE;
          else               cnt_n = cnt_q + 1'b1;
        end
        PM_ACTIVE: if (pm_req_vld) begin
          if (pm_req == REQ_RESTART) begin
            st_n  = PM_STARTUP;
            cnt_n = '0;
          end else if (pm_req == REQ_SLEEP) begin
            st_n = PM_LOWPWR;
          end
        end
        PM_LOWPWR: if (pm_req_vld) begin
          if (pm_req == REQ_RESTART) begin
            st_n  = PM_STARTUP;
            cnt_n = '0;
          end else if (pm_req == REQ_RUN) begin
            st_n = PM_ACTIVE;
          end
        end
        default: st_n = PM_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PM_OFF;
      vio_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      vio_q <= vio_ok;
      cnt_q <= cnt_n;
    end
  end

  // R1: a low supply level always lands in shutdown
  a_r1_off_when_low: assert property (@(posedge clk) disable iff (rst)
    !vio_ok |=> (st_q == PM_OFF));

  // R3: startup holds until its counter has reached the last cycle
  a_r3_startup_holds: assert property (@(posedge clk) disable iff (rst)
    (st_q == PM_STARTUP && cnt_q != LAST && vio_ok) |=> (st_q == PM_STARTUP));

  // R3: leaving startup for active happens only at the last count
  a_r3_startup_exit: assert property (@(posedge clk) disable iff (rst)
    (st_q == PM_ACTIVE && $past(st_q) == PM_STARTUP) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/tbc_ctrl_regs.sv
module tbc_ctrl_regs
  import tbc_pkg::*;
#(
  parameter int                N_OUT     = 3,
  parameter int                CODE_W    = 7,
  parameter int                BOOST_W   = 4,
  parameter logic [BOOST_W-1:0] BOOST_DEF = 4'hB
) (
  input  logic                    clk,
  input  logic                    rst,
  input  pm_state_t               st_q,
  input  pm_state_t               st_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    pm_req_vld,
  output logic [1:0]              pm_req,
  output logic [N_OUT-1:0]        mask_n,
  output logic [N_OUT-1:0]        dac_nz_n,
  output logic [BOOST_W-1:0]      boost_q,
  output logic [N_OUT*CODE_W-1:0] dac_flat
);
  logic               wr_ok;
  logic               clear;
  logic [N_OUT-1:0]   mask_q;
  logic [BOOST_W-1:0] boost_n;

  assign wr_ok      = wr_en && (st_q == PM_ACTIVE || st_q == PM_LOWPWR);
  assign clear      = (st_n == PM_OFF) || (st_n == PM_STARTUP);
  assign pm_req_vld = wr_ok && (wr_addr == A_PMODE);
  assign pm_req     = wr_data[7:6];

  always_comb begin
    mask_n  = mask_q;
    boost_n = boost_q;
    if (clear) begin
      mask_n  = '0;
      boost_n = BOOST_DEF;
    end else if (wr_ok) begin
      if (wr_addr == A_MASK)  mask_n  = wr_data[N_OUT-1:0];
      if (wr_addr == A_BOOST) boost_n = wr_data[BOOST_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      boost_q <= BOOST_DEF;
    end else begin
      mask_q  <= mask_n;
      boost_q <= boost_n;
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_dac
    localparam logic [ADDR_W-1:0] A_THIS = A_DAC0 + ADDR_W'(g);
    logic [CODE_W-1:0] code_q, code_n;

    always_comb begin
      code_n = code_q;
      if (clear)                              code_n = '0;
      else if (wr_ok && wr_addr == A_THIS)    code_n = wr_data[CODE_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) code_q <= '0;
      else     code_q <= code_n;
    end

    assign dac_flat[g*CODE_W +: CODE_W] = code_q;
    assign dac_nz_n[g]                  = |code_n;
  end

  // R2: register contents sit at their defaults throughout startup
  a_r2_defaults_in_startup: assert property (@(posedge clk) disable iff (rst)
    (st_q == PM_STARTUP) |-> (mask_q == '0 && boost_q == BOOST_DEF));

  // R6: entering low power leaves the held settings untouched
  a_r6_lowpower_keeps: assert property (@(posedge clk) disable iff (rst)
    (st_q == PM_LOWPWR && $past(st_q) == PM_ACTIVE) |-> ($stable(mask_q) && $stable(boost_q)));
endmodule

// File: rtl/tbc_out_drive.sv
module tbc_out_drive
  import tbc_pkg::*;
#(
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  pm_state_t        st_n,
  input  logic [N_OUT-1:0] mask_n,
  input  logic [N_OUT-1:0] nz_n,
  output logic             boost_en,
  output logic             iface_en,
  output logic             regs_clr,
  output logic [N_OUT-1:0] out_drv,
  output logic [N_OUT-1:0] out_hiz,
  output logic [N_OUT-1:0] out_pd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      boost_en <= 1'b0;
      iface_en <= 1'b0;
      regs_clr <= 1'b1;
    end else begin
      boost_en <= (st_n == PM_STARTUP) || (st_n == PM_ACTIVE);
      iface_en <= (st_n != PM_OFF);
      regs_clr <= (st_n == PM_OFF) || (st_n == PM_STARTUP);
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        out_drv[g] <= 1'b0;
        out_hiz[g] <= 1'b1;
        out_pd[g]  <= 1'b0;
      end else if (st_n == PM_ACTIVE && mask_n[g]) begin
        out_drv[g] <= nz_n[g];
        out_hiz[g] <= 1'b0;
        out_pd[g]  <= ~nz_n[g];
      end else begin
        out_drv[g] <= 1'b0;
        out_hiz[g] <= 1'b1;
        out_pd[g]  <= 1'b0;
      end
    end

    // R5: each output is in exactly one drive state
    a_r5_single_state: assert property (@(posedge clk) disable iff (rst)
      $onehot({out_drv[g], out_hiz[g], out_pd[g]}));
  end
endmodule

// File: rtl/tuner_bias_ctrl.sv
module tuner_bias_ctrl
  import tbc_pkg::*;
#(
  parameter int                N_OUT     = 3,
  parameter int                CODE_W    = 7,
  parameter int                BOOST_W   = 4,
  parameter logic [BOOST_W-1:0] BOOST_DEF = 4'hB,
  parameter int                START_CYC = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vio_ok,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [1:0]              mode_o,
  output logic                    boost_en,
  output logic [BOOST_W-1:0]      boost_code,
  output logic                    iface_en,
  output logic                    regs_clr,
  output logic [N_OUT-1:0]        out_drv,
  output logic [N_OUT-1:0]        out_hiz,
  output logic [N_OUT-1:0]        out_pd,
  output logic [N_OUT*CODE_W-1:0] dac_code
);
  pm_state_t        st_q, st_n;
  logic             pm_req_vld;
  logic [1:0]       pm_req;
  logic [N_OUT-1:0] mask_n, nz_n;

  tbc_mode_fsm #(.START_CYC(START_CYC)) u_fsm (
    .clk(clk), .rst(rst), .vio_ok(vio_ok),
    .pm_req_vld(pm_req_vld), .pm_req(pm_req),
    .st_q(st_q), .st_n(st_n)
  );

  tbc_ctrl_regs #(
    .N_OUT(N_OUT), .CODE_W(CODE_W), .BOOST_W(BOOST_W), .BOOST_DEF(BOOST_DEF)
  ) u_regs (
    .clk(clk), .rst(rst), .st_q(st_q), .st_n(st_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pm_req_vld(pm_req_vld), .pm_req(pm_req),
    .mask_n(mask_n), .dac_nz_n(nz_n),
    .boost_q(boost_code), .dac_flat(dac_code)
  );

  tbc_out_drive #(.N_OUT(N_OUT)) u_drv (
    .clk(clk), .rst(rst), .st_n(st_n), .mask_n(mask_n), .nz_n(nz_n),
    .boost_en(boost_en), .iface_en(iface_en), .regs_clr(regs_clr),
    .out_drv(out_drv), .out_hiz(out_hiz), .out_pd(out_pd)
  );

  assign mode_o = st_q;

  logic [N_OUT-1:0] code_nz;
  for (genvar g = 0; g < N_OUT; g++) begin : g_nz
    assign code_nz[g] = |dac_code[g*CODE_W +: CODE_W];
  end

  // R1: shutdown keeps everything off and floating
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_o == PM_OFF) |-> (!boost_en && !iface_en && regs_clr && (&out_hiz)));

  // R6: low power turns the boost off and floats every output
  a_r6_lowpower_outputs: assert property (@(posedge clk) disable iff (rst)
    (mode_o == PM_LOWPWR) |-> (!boost_en && iface_en && !regs_clr && (&out_hiz)));

  // R5: a driven output always carries a non-zero code
  a_r5_drive_needs_code: assert property (@(posedge clk) disable iff (rst)
    (out_drv & ~code_nz) == '0);

  // R2: startup runs the boost while all outputs float
  a_r2_startup_outputs: assert property (@(posedge clk) disable iff (rst)
    (mode_o == PM_STARTUP) |-> (boost_en && iface_en && regs_clr && (&out_hiz)));
endmodule

// File: tb/tb_tuner_bias_ctrl.sv
module tb_tuner_bias_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int START_CYC  = 6;

  logic        clk = 1'b0;
  logic        rst, vio_ok, wr_en;
  logic [4:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [1:0]  mode_o;
  logic        boost_en, iface_en, regs_clr;
  logic [3:0]  boost_code;
  logic [2:0]  out_drv, out_hiz, out_pd;
  logic [20:0] dac_code;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // model state: 0 active, 1 startup, 2 low power, 3 shutdown
  logic [1:0] m_st;
  int         m_cnt;
  logic [2:0] m_mask;
  logic [6:0] m_dac [3];
  logic [3:0] m_boost;

  tuner_bias_ctrl #(.START_CYC(START_CYC)) dut (
    .clk(clk), .rst(rst), .vio_ok(vio_ok), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .mode_o(mode_o),
    .boost_en(boost_en), .boost_code(boost_code), .iface_en(iface_en),
    .regs_clr(regs_clr), .out_drv(out_drv), .out_hiz(out_hiz),
    .out_pd(out_pd), .dac_code(dac_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic m_defaults();
    m_mask  = 3'b000;
    m_boost = 4'b1011;
    for (int i = 0; i < 3; i++) m_dac[i] = 7'd0;
  endtask

  task automatic m_step(input logic v, input logic we, input logic [4:0] a, input logic [7:0] d);
    if (!v) begin
      m_st = 2'd3;
      m_defaults();
    end else begin
      case (m_st)
        2'd3: begin m_st = 2'd1; m_cnt = 0; m_defaults(); end
        2'd1: if (m_cnt == START_CYC-1) m_st = 2'd0; else m_cnt++;
        default: if (we) begin
          if (a == 5'h1C) begin
            if (d[7:6] == 2'b01) begin m_st = 2'd1; m_cnt = 0; m_defaults(); end
            else if (d[7:6] == 2'b10 && m_st == 2'd0) m_st = 2'd2;
            else if (d[7:6] == 2'b00 && m_st == 2'd2) m_st = 2'd0;
          end else if (a == 5'h00) m_mask = d[2:0];
          else if (a >= 5'h02 && a <= 5'h04) m_dac[a-5'h02] = d[6:0];
          else if (a == 5'h10) m_boost = d[3:0];
        end
      endcase
    end
  endtask

  function automatic logic [38:0] expv();
    logic be, ie, cl;
    logic [2:0] dv, hz, pd;
    logic [20:0] dc;
    dv = 3'b000; pd = 3'b000; hz = 3'b111;
    be = (m_st == 2'd0) || (m_st == 2'd1);
    ie = (m_st != 2'd3);
    cl = (m_st == 2'd3) || (m_st == 2'd1);
    for (int i = 0; i < 3; i++) begin
      dc[i*7 +: 7] = m_dac[i];
      if (m_st == 2'd0 && m_mask[i]) begin
        hz[i] = 1'b0;
        if (m_dac[i] == 7'd0) pd[i] = 1'b1;
        else                  dv[i] = 1'b1;
      end
    end
    return {m_st, be, ie, cl, m_boost, dv, hz, pd, dc};
  endfunction

  task automatic check(input string tag);
    logic [38:0] act, ex;
    act = {mode_o, boost_en, iface_en, regs_clr, boost_code, out_drv, out_hiz, out_pd, dac_code};
    ex  = expv();
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, ex);
    end
  endtask

  // entered and left at a falling edge
  task automatic step(input logic v, input logic we, input logic [4:0] a,
                      input logic [7:0] d, input string tag);
    vio_ok = v; wr_en = we; wr_addr = a; wr_data = d;
    m_step(v, we, a, d);
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 5'h00, 8'h00, tag);
  endtask

  function automatic string tag_of(input logic [1:0] s);
    case (s)
      2'd0: return "R5";
      2'd1: return "R3";
      2'd2: return "R6";
      default: return "R1";
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240607));
    rst = 1'b1; vio_ok = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    m_st = 2'd3; m_cnt = 0; m_defaults();
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1");
    @(negedge clk);
    rst = 1'b0;

    step(1'b0, 1'b0, 5'h00, 8'h00, "R1");
    step(1'b1, 1'b0, 5'h00, 8'h00, "R2");
    step(1'b1, 1'b1, 5'h00, 8'h07, "R4");   // write ignored during startup
    idle(START_CYC - 2, "R3");
    idle(1, "R3");                          // first active cycle
    idle(20, "R3");                         // edge-triggered: stays active

    step(1'b1, 1'b1, 5'h00, 8'h07, "R4");
    step(1'b1, 1'b1, 5'h02, 8'hD5, "R4");   // bit 7 dropped
    step(1'b1, 1'b1, 5'h04, 8'h7F, "R4");
    step(1'b1, 1'b1, 5'h03, 8'h00, "R5");   // B pulled down
    step(1'b1, 1'b1, 5'h10, 8'h03, "R4");
    step(1'b1, 1'b1, 5'h05, 8'hFF, "R4");   // unmapped address
    step(1'b1, 1'b1, 5'h00, 8'h05, "R5");   // B floats
    step(1'b1, 1'b1, 5'h1C, 8'hC0, "R8");
    step(1'b1, 1'b1, 5'h1C, 8'h00, "R8");

    step(1'b1, 1'b1, 5'h1C, 8'h80, "R6");
    step(1'b1, 1'b1, 5'h1C, 8'h80, "R8");
    step(1'b1, 1'b1, 5'h02, 8'h11, "R9");
    step(1'b1, 1'b1, 5'h10, 8'h0F, "R9");
    step(1'b1, 1'b1, 5'h00, 8'h03, "R9");
    step(1'b1, 1'b1, 5'h1C, 8'h00, "R6");

    step(1'b1, 1'b1, 5'h1C, 8'h40, "R7");
    idle(START_CYC, "R7");
    step(1'b1, 1'b1, 5'h00, 8'h01, "R4");
    step(1'b1, 1'b1, 5'h1C, 8'h80, "R6");
    step(1'b1, 1'b1, 5'h1C, 8'h7F, "R7");   // field 01 from low power
    idle(START_CYC, "R7");

    step(1'b0, 1'b1, 5'h02, 8'h33, "R1");   // supply drop beats the write
    step(1'b0, 1'b1, 5'h00, 8'h07, "R4");   // ignored in shutdown
    step(1'b1, 1'b0, 5'h00, 8'h00, "R2");
    idle(START_CYC, "R3");

    for (int n = 0; n < 700; n++) begin
      int r;
      logic [4:0] a;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      d = 8'($urandom);
      case ($urandom_range(0, 6))
        0: a = 5'h00;
        1: a = 5'h02;
        2: a = 5'h03;
        3: a = 5'h04;
        4: a = 5'h10;
        5: a = 5'h1C;
        default: a = 5'($urandom);
      endcase
      if (r < 3) step(1'b0, 1'b0, a, d, "R1");
      else begin
        logic [1:0] pre;
        pre = m_st;
        step(1'b1, (r < 60), a, d, tag_of(pre == 2'd3 ? 2'd1 : m_st));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule